// File: doc/BRIEF.md
# Age-Ordered Transaction Conflict Resolver

This block sits at a core that answers coherence requests while a hardware transaction may be running there. When a remote request hits the local read or write set, the resolver works out the kind of clash and compares transaction ages. Under the selected policy it then either refuses the request, so the requester waits, or asks the local transaction to abort. A refusal names the requester. It carries the clash kinds seen so far with that requester, plus a flag telling whether the responder is the elder.

A table holds one entry per remote core, recording every clash kind met during the current local transaction. The table also remembers which elder requesters were refused. When the local core later finds itself stalled by one of those elder cores, a deadlock is possible, and the resolver aborts the local side, which is the younger one. Each abort is tagged read-dependent or write-dependent. Signature lookup, the coherence protocol and log rollback belong to other blocks.

Top module: `txres_resolver`

## Requirements
- R1: Clash kind is a 3-bit mask. Bit 0 (RW) is set when the local side only read the line and the requester writes. Bit 1 (WR) is set when the local side wrote the line and the requester reads. Bit 2 (WW) is set when the local side wrote the line and the requester writes. A request that produces no kind is not a conflict.
- R2: While `local_active` is low, no refusal and no abort are produced, whatever the requests and stall inputs are.
- R3: Under policy code 0 (base), every conflicting request is refused and causes no abort.
- R4: Under policy code 1 (timestamp), an elder requester aborts the local transaction, and a younger requester is refused.
- R5: Under policy code 2 (hybrid), an RW conflict from an elder requester aborts the local transaction. Every other conflict is refused.
- R6: The transaction with the smaller timestamp is the elder. When the timestamps are equal, the transaction on the core with the lower core ID is the elder.
- R7: A refusal carries the requester ID in `nack_dest`. `nack_kinds` holds the OR of all kinds recorded with that requester, including the current one. `nack_elder` is 1 when the responder is the elder.
- R8: If the local core refused an elder requester X during the current transaction, and `stall_valid` is then asserted with `stall_core_id` = X, `abort_req` is raised.
- R9: `abort_rd_dep` is 1 with an abort only when the OR of all kinds in the transaction, including the current one, equals RW alone.
- R10: `rec_table` holds 3 kind bits per remote core, with core i at bits [3i+2:3i]. It is updated on the edge after a conflict and cleared on the edge after `local_active` is seen low.
- R11: Every result appears on the first clock edge after the request. Refusal and abort are never raised together.
- R12: Policy code 3 behaves as policy code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_core_id | input | ID_W | ID of this core |
| policy_sel | input | 2 | Policy: 0 base, 1 timestamp, 2 hybrid, 3 as base |
| local_active | input | 1 | A local transaction is running |
| local_ts | input | TS_W | Timestamp of the local transaction |
| req_valid | input | 1 | Remote request present |
| req_is_write | input | 1 | Remote request wants to write |
| req_core_id | input | ID_W | Requesting core |
| req_ts | input | TS_W | Requester transaction timestamp |
| sig_rd_hit | input | 1 | Request address hits the local read set |
| sig_wr_hit | input | 1 | Request address hits the local write set |
| stall_valid | input | 1 | Local core is currently stalled by a remote core |
| stall_core_id | input | ID_W | Core that is stalling the local core |
| nack_valid | output | 1 | Refuse the request |
| nack_dest | output | ID_W | Core the refusal goes to |
| nack_kinds | output | 3 | Clash kinds seen with that core |
| nack_elder | output | 1 | Responder is the elder |
| abort_req | output | 1 | Abort the local transaction |
| abort_rd_dep | output | 1 | Abort is read-dependent |
| rec_table | output | 3*NCORES | Per-core clash record |

## Verification
Refusals, aborts and their metadata are registered once, so each result is due on the first rising edge after the cycle in which the request or stall was driven. The driver applies stimulus at the falling edge and queues the expected result at that moment. The monitor pops the queue just after the next rising edge, which pairs each result with exactly one stimulus cycle. The record table follows the same one-edge delay and is read at that same point, right after the step that should have changed or cleared it.

// File: rtl/txres_pkg.sv
package txres_pkg;

    localparam int KIND_W = 3;
    localparam int K_RW   = 0;
    localparam int K_WR   = 1;
    localparam int K_WW   = 2;

    typedef logic [KIND_W-1:0] kind_t;

    typedef enum logic [1:0] {
        POL_BASE   = 2'd0,
        POL_STAMP  = 2'd1,
        POL_HYBRID = 2'd2,
        POL_SPARE  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_NACK  = 2'd1,
        ACT_ABORT = 2'd2
    } action_e;

    // Mask with the single kind that this access pair produces.
    function automatic kind_t kind_of(input logic remote_wr,
                                      input logic rd_hit,
                                      input logic wr_hit);
        kind_t k;
        k = '0;
        if (wr_hit && remote_wr)       k[K_WW] = 1'b1;
        else if (wr_hit && !remote_wr) k[K_WR] = 1'b1;
        else if (rd_hit && remote_wr)  k[K_RW] = 1'b1;
        return k;
    endfunction

endpackage

// File: rtl/txres_classify.sv
module txres_classify
    import txres_pkg::*;
(
    input  logic  req_valid,
    input  logic  local_active,
    input  logic  req_is_write,
    input  logic  sig_rd_hit,
    input  logic  sig_wr_hit,
    output kind_t kind,
    output logic  hit
);
    always_comb begin
        kind = kind_of(req_is_write, sig_rd_hit, sig_wr_hit);
        hit  = req_valid && local_active && (kind != '0);
    end
endmodule

// File: rtl/txres_decide.sv
module txres_decide
    import txres_pkg::*;
#(
    parameter int TS_W = 16,
    parameter int ID_W = 2
) (
    input  logic [1:0]      policy_sel,
    input  logic            hit,
    input  kind_t           kind,
    input  logic [TS_W-1:0] local_ts,
    input  logic [TS_W-1:0] req_ts,
    input  logic [ID_W-1:0] my_core_id,
    input  logic [ID_W-1:0] req_core_id,
    output action_e         act,
    output logic            elder
);
    policy_e pol;

    always_comb begin
        pol   = policy_e'(policy_sel);
        elder = (local_ts < req_ts) ||
                ((local_ts == req_ts) && (my_core_id < req_core_id));
        act   = ACT_NONE;
        if (hit) begin
            unique case (pol)
                POL_STAMP:  act = elder ? ACT_NACK : ACT_ABORT;
                POL_HYBRID: act = (!elder && kind[K_RW]) ? ACT_ABORT : ACT_NACK;
                default:    act = ACT_NACK;
            endcase
        end
    end
endmodule

// File: rtl/txres_table.sv
module txres_table
    import txres_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int ID_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     active,
    input  logic                     upd,
    input  logic [ID_W-1:0]          upd_id,
    input  kind_t                    upd_kind,
    input  logic                     mark,
    input  logic [ID_W-1:0]          stall_id,
    output kind_t                    seen_kind,
    output kind_t                    all_kind,
    output logic                     stall_pending,
    output logic [KIND_W*NCORES-1:0] rec_flat
);
    kind_t            rec_q [NCORES];
    logic [NCORES-1:0] pend_q;

    for (genvar i = 0; i < NCORES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || !active) begin
                rec_q[i]  <= '0;
                pend_q[i] <= 1'b0;
            end else begin
                if (upd && (upd_id == ID_W'(i)))  rec_q[i]  <= rec_q[i] | upd_kind;
                if (mark && (upd_id == ID_W'(i))) pend_q[i] <= 1'b1;
            end
        end
        assign rec_flat[KIND_W*i +: KIND_W] = rec_q[i];
    end

    always_comb begin
        all_kind = '0;
        for (int i = 0; i < NCORES; i++) all_kind = all_kind | rec_q[i];
        seen_kind     = rec_q[upd_id];
        stall_pending = pend_q[stall_id];
    end

    assert_table_clear_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> (rec_flat == '0));

endmodule

// File: rtl/txres_resolver.sv
module txres_resolver
    import txres_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int TS_W   = 16,
    localparam int ID_W  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ID_W-1:0]          my_core_id,
    input  logic [1:0]               policy_sel,
    input  logic                     local_active,
    input  logic [TS_W-1:0]          local_ts,
    input  logic                     req_valid,
    input  logic                     req_is_write,
    input  logic [ID_W-1:0]          req_core_id,
    input  logic [TS_W-1:0]          req_ts,
    input  logic                     sig_rd_hit,
    input  logic                     sig_wr_hit,
    input  logic                     stall_valid,
    input  logic [ID_W-1:0]          stall_core_id,
    output logic                     nack_valid,
    output logic [ID_W-1:0]          nack_dest,
    output logic [KIND_W-1:0]        nack_kinds,
    output logic                     nack_elder,
    output logic                     abort_req,
    output logic                     abort_rd_dep,
    output logic [KIND_W*NCORES-1:0] rec_table
);
    kind_t   kind, seen_kind, all_kind, total_kind;
    logic    hit, elder, stall_pending, deadlock;
    logic    nack_n, abort_n, mark;
    action_e act;

    txres_classify u_classify (
        .req_valid    (req_valid),
        .local_active (local_active),
        .req_is_write (req_is_write),
        .sig_rd_hit   (sig_rd_hit),
        .sig_wr_hit   (sig_wr_hit),
        .kind         (kind),
        .hit          (hit)
    );

    txres_decide #(.TS_W(TS_W), .ID_W(ID_W)) u_decide (
        .policy_sel  (policy_sel),
        .hit         (hit),
        .kind        (kind),
        .local_ts    (local_ts),
        .req_ts      (req_ts),
        .my_core_id  (my_core_id),
        .req_core_id (req_core_id),
        .act         (act),
        .elder       (elder)
    );

    txres_table #(.NCORES(NCORES), .ID_W(ID_W)) u_table (
        .clk           (clk),
        .rst           (rst),
        .active        (local_active),
        .upd           (hit),
        .upd_id        (req_core_id),
        .upd_kind      (kind),
        .mark          (mark),
        .stall_id      (stall_core_id),
        .seen_kind     (seen_kind),
        .all_kind      (all_kind),
        .stall_pending (stall_pending),
        .rec_flat      (rec_table)
    );

    always_comb begin
        deadlock   = local_active && stall_valid && stall_pending;
        abort_n    = (act == ACT_ABORT) || deadlock;
        nack_n     = (act == ACT_NACK) && !deadlock;
        mark       = nack_n && !elder;
        total_kind = all_kind | (hit ? kind : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nack_valid   <= 1'b0;
            nack_dest    <= '0;
            nack_kinds   <= '0;
            nack_elder   <= 1'b0;
            abort_req    <= 1'b0;
            abort_rd_dep <= 1'b0;
        end else begin
            nack_valid   <= nack_n;
            nack_dest    <= nack_n ? req_core_id : '0;
            nack_kinds   <= nack_n ? (seen_kind | kind) : '0;
            nack_elder   <= nack_n && elder;
            abort_req    <= abort_n;
            abort_rd_dep <= abort_n && (total_kind == kind_t'(1 << K_RW));
        end
    end

    assert_one_action_R11: assert property (@(posedge clk) disable iff (rst)
        !(nack_valid && abort_req));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(local_active) |-> (!nack_valid && !abort_req));

    assert_nack_has_kind_R7: assert property (@(posedge clk) disable iff (rst)
        nack_valid |-> (nack_kinds != '0));

    assert_rddep_with_abort_R9: assert property (@(posedge clk) disable iff (rst)
        abort_rd_dep |-> abort_req);

    assert_deadlock_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (local_active && stall_valid && stall_pending) |=> abort_req);

endmodule

// File: tb/txres_resolver_tb.sv
`timescale 1ns/1ps
module txres_resolver_tb;

    typedef struct {
        bit       nv;
        bit [2:0] nk;
        bit       ne;
        bit [1:0] nd;
        bit       ab;
        bit       rd;
        string    tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  my_core_id = 2'd1;
    logic [1:0]  policy_sel = 2'd0;
    logic        local_active = 1'b0;
    logic [15:0] local_ts = 16'd100;
    logic        req_valid = 1'b0, req_is_write = 1'b0;
    logic [1:0]  req_core_id = 2'd0;
    logic [15:0] req_ts = 16'd0;
    logic        sig_rd_hit = 1'b0, sig_wr_hit = 1'b0;
    logic        stall_valid = 1'b0;
    logic [1:0]  stall_core_id = 2'd0;
    logic        nack_valid, nack_elder, abort_req, abort_rd_dep;
    logic [1:0]  nack_dest;
    logic [2:0]  nack_kinds;
    logic [11:0] rec_table;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    txres_resolver #(.NCORES(4), .TS_W(16)) u_dut (
        .clk(clk), .rst(rst), .my_core_id(my_core_id), .policy_sel(policy_sel),
        .local_active(local_active), .local_ts(local_ts), .req_valid(req_valid),
        .req_is_write(req_is_write), .req_core_id(req_core_id), .req_ts(req_ts),
        .sig_rd_hit(sig_rd_hit), .sig_wr_hit(sig_wr_hit), .stall_valid(stall_valid),
        .stall_core_id(stall_core_id), .nack_valid(nack_valid), .nack_dest(nack_dest),
        .nack_kinds(nack_kinds), .nack_elder(nack_elder), .abort_req(abort_req),
        .abort_rd_dep(abort_rd_dep), .rec_table(rec_table)
    );

    task automatic step(bit act, bit [1:0] pol, bit rv, bit rw, bit rh, bit wh,
                        bit [15:0] rts, bit [1:0] rid, bit sv, bit [1:0] sid,
                        bit en, bit [2:0] ek, bit eo, bit ea, bit erd, string tag);
        exp_t e;
        @(negedge clk);
        local_active = act; policy_sel = pol; req_valid = rv; req_is_write = rw;
        sig_rd_hit = rh; sig_wr_hit = wh; req_ts = rts; req_core_id = rid;
        stall_valid = sv; stall_core_id = sid;
        e.nv = en; e.nk = ek; e.ne = eo; e.nd = rid; e.ab = ea; e.rd = erd; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check_table(bit [11:0] expv, string tag);
        @(posedge clk);
        #2;
        checks++;
        if (rec_table !== expv) begin
            errors++;
            $display("FAIL %s rec_table actual %h expected %h", tag, rec_table, expv);
        end
    endtask

    // Monitor: compare one queued expectation just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                bit   bad;
                e = q.pop_front();
                checks++;
                bad = (nack_valid !== e.nv) || (abort_req !== e.ab) ||
                      (e.nv && ((nack_kinds !== e.nk) || (nack_elder !== e.ne) ||
                                (nack_dest !== e.nd))) ||
                      (e.ab && (abort_rd_dep !== e.rd));
                if (bad) begin
                    errors++;
                    $display("FAIL %s actual nack=%b kinds=%b elder=%b dest=%0d abort=%b rd=%b expected nack=%b kinds=%b elder=%b dest=%0d abort=%b rd=%b",
                             e.tag, nack_valid, nack_kinds, nack_elder, nack_dest,
                             abort_req, abort_rd_dep, e.nv, e.nk, e.ne, e.nd, e.ab, e.rd);
                end
            end
        end
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (nack_valid !== 1'b0 || abort_req !== 1'b0 || rec_table !== 12'h0) begin
            errors++;
            $display("FAIL R2 reset actual nack=%b abort=%b table=%h expected 0 0 000",
                     nack_valid, abort_req, rec_table);
        end
        //    act pol rv rw rh wh ts  id sv sid en kinds eo ea rd
        step(0, 0, 1, 1, 1, 0, 50, 2, 0, 0, 0, 3'b000, 0, 0, 0, "R2 inactive request");
        step(1, 0, 1, 1, 1, 0, 50, 2, 0, 0, 1, 3'b001, 0, 0, 0, "R3 R1 base RW older req");
        step(1, 0, 1, 0, 0, 1, 200, 3, 0, 0, 1, 3'b010, 1, 0, 0, "R1 base WR");
        step(1, 0, 1, 1, 0, 1, 200, 3, 0, 0, 1, 3'b110, 1, 0, 0, "R7 accumulated WW");
        check_table(12'b110_001_000_000, "R10 table contents");
        step(1, 0, 0, 0, 0, 0, 0, 2, 1, 2, 0, 3'b000, 0, 1, 0, "R8 R9 deadlock abort");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, "R2 idle");
        check_table(12'h000, "R10 table cleared");
        step(1, 1, 1, 1, 1, 0, 50, 0, 0, 0, 0, 3'b000, 0, 1, 1, "R4 R9 elder req aborts");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, "R2 idle");
        step(1, 1, 1, 1, 0, 1, 300, 2, 0, 0, 1, 3'b100, 1, 0, 0, "R4 younger req refused");
        step(1, 1, 1, 1, 1, 0, 100, 0, 0, 0, 0, 3'b000, 0, 1, 0, "R6 tie lower id wins");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, "R2 idle");
        step(1, 1, 1, 1, 1, 0, 100, 3, 0, 0, 1, 3'b001, 1, 0, 0, "R6 tie higher id loses");
        step(0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, "R2 idle");
        step(1, 2, 1, 1, 1, 0, 50, 0, 0, 0, 0, 3'b000, 0, 1, 1, "R5 hybrid RW elder aborts");
        step(0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, "R2 idle");
        step(1, 2, 1, 0, 0, 1, 50, 0, 0, 0, 1, 3'b010, 0, 0, 0, "R5 hybrid WR elder refused");
        step(1, 2, 1, 1, 1, 0, 200, 3, 0, 0, 1, 3'b001, 1, 0, 0, "R5 hybrid RW younger refused");
        step(1, 3, 1, 1, 1, 0, 50, 0, 0, 0, 1, 3'b011, 0, 0, 0, "R12 spare acts as base");
        step(1, 0, 1, 0, 1, 0, 50, 0, 0, 0, 0, 3'b000, 0, 0, 0, "R11 read vs read no conflict");
        step(1, 0, 1, 1, 0, 0, 50, 0, 0, 0, 0, 3'b000, 0, 0, 0, "R11 no hit");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 3'b000, 0, 1, 0, "R8 stall by refused elder");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 3'b000, 0, 0, 0, "R2 stall while inactive");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0, 0, "R2 idle");
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule